// File: doc/BRIEF.md
# Serial DAC Command Word Transmitter

This block sends a 16-bit command to a write-only serial DAC. A start strobe captures four control bits and a 12-bit output code. The control bits are channel select, reference buffer enable, gain select and power-on. The block then shifts the word out most significant bit first on MOSI. It drives an active-low chip select and a serial clock that runs at half the system clock. The link uses SPI mode 0: the clock idles low, MOSI changes after a falling edge, and the receiver samples on the rising edge.

A parallel-load shift register and a bit counter do the serializing. The block has no state for each bit. Busy covers the whole transfer. A one-cycle done pulse marks the moment chip select returns high. While the block is busy it ignores start, and once a frame is under way it ignores changes on the data inputs. A new start is accepted in the same cycle as done, so frames can be sent back to back.

Top module: `dac_cmd_tx`

## Requirements
- R1: A synchronous active-high reset drives cs_n high and drives sclk, mosi, busy and done low, including when it arrives in the middle of a frame.
- R2: A start seen while idle is accepted. In the cycle after that edge, busy is high, cs_n is low and sclk is low, so cs_n is low for at least one full cycle before the first rising sclk.
- R3: sclk is low whenever cs_n is high. During a frame it stays high for exactly one system clock and its rising edges come exactly two system clocks apart.
- R4: Each frame has exactly 16 rising sclk edges. The bits on MOSI, in order, are ch_sel, buf_en, gain_sel, pwr_on, then code[11] down to code[0].
- R5: MOSI holds its value across every rising sclk edge. It changes only in the cycle in which sclk falls, or when a frame starts.
- R6: After the 16th rising edge, sclk goes low and stays low for one cycle with cs_n still low. On the next edge cs_n goes high, done is high for exactly that one cycle, and busy is low in that cycle. From the cycle after the start was accepted, this is the 33rd cycle.
- R7: A start pulse while busy is high has no effect: the current frame is unchanged and no extra frame follows it.
- R8: The control bits and the code are captured on the accepted start cycle. Changing them later does not alter the frame in progress.
- R9: A start raised in the cycle in which done is high is accepted. The next frame begins after cs_n has been high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to send one frame |
| ch_sel | input | 1 | Channel select bit (first bit sent) |
| buf_en | input | 1 | Reference buffer enable bit |
| gain_sel | input | 1 | Gain select bit |
| pwr_on | input | 1 | Power-on bit (clear means shutdown) |
| code | input | 12 | DAC output code, sent MSB first |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse as cs_n returns high |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |

## Verification
Two events can land in the same cycle: the done pulse that closes one frame, and a start request for the next. The bench provokes this by raising start exactly in the done cycle. It expects cs_n to be high for a single sampled cycle, busy to rise on the following one, and the second frame to arrive complete and correct. It also checks a start that lands in the middle of a busy frame: the first frame must be unchanged, and no stray frame may follow it.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;
    localparam int CTRL_BITS = 4;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_TAIL  = 2'd2
    } tx_phase_e;
endpackage

// File: rtl/dac_frame_pack.sv
module dac_frame_pack #(
    parameter int CODE_W = 12,
    parameter int SR_W   = 16
) (
    input  logic              ch_sel,
    input  logic              buf_en,
    input  logic              gain_sel,
    input  logic              pwr_on,
    input  logic [CODE_W-1:0] code,
    output logic [SR_W-1:0]   word
);
    localparam int FRAME_W = dac_tx_pkg::CTRL_BITS + CODE_W;

    logic [FRAME_W-1:0] frame;
    assign frame = {ch_sel, buf_en, gain_sel, pwr_on, code};

    // Frame sits in the low bits; any spare upper bits are zero.
    generate
        if (SR_W > FRAME_W) begin : g_pad
            assign word = {{(SR_W - FRAME_W){1'b0}}, frame};
        end else begin : g_exact
            assign word = frame;
        end
    endgenerate
endmodule

// File: rtl/dac_tx_engine.sv
module dac_tx_engine #(
    parameter int SR_W    = 16,
    parameter int FRAME_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [SR_W-1:0] load_word,
    output logic            sclk,
    output logic            cs_n,
    output logic            mosi,
    output logic            busy,
    output logic            done
);
    import dac_tx_pkg::*;

    localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        tx_phase_e        phase;
        logic [SR_W-1:0]  sr;
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic             cs_n;
        logic             done;
    } regs_t;

    localparam regs_t RST_VAL = '{
        phase: TX_IDLE,
        sr:    '0,
        cnt:   '0,
        sclk:  1'b0,
        cs_n:  1'b1,
        done:  1'b0
    };

    regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.phase)
            TX_IDLE: begin
                if (start) begin
                    r_d.phase = TX_SHIFT;
                    r_d.sr    = load_word;
                    r_d.cnt   = '0;
                    r_d.cs_n  = 1'b0;
                    r_d.sclk  = 1'b0;
                end
            end
            TX_SHIFT: begin
                if (!r_q.sclk) begin
                    r_d.sclk = 1'b1;
                end else begin
                    r_d.sclk = 1'b0;
                    r_d.sr   = r_q.sr << 1;
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.phase = TX_TAIL;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            TX_TAIL: begin
                r_d.phase = TX_IDLE;
                r_d.cs_n  = 1'b1;
                r_d.done  = 1'b1;
                r_d.cnt   = '0;
                r_d.sr    = '0;
            end
            default: r_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk = r_q.sclk;
    assign cs_n = r_q.cs_n;
    assign mosi = r_q.sr[FRAME_W-1];
    assign busy = (r_q.phase != TX_IDLE);
    assign done = r_q.done;
endmodule

// File: rtl/dac_cmd_tx.sv
module dac_cmd_tx #(
    parameter int CODE_W = 12,
    parameter int SR_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ch_sel,
    input  logic              buf_en,
    input  logic              gain_sel,
    input  logic              pwr_on,
    input  logic [CODE_W-1:0] code,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi
);
    localparam int FRAME_W = dac_tx_pkg::CTRL_BITS + CODE_W;

    logic [SR_W-1:0] load_word;

    dac_frame_pack #(
        .CODE_W (CODE_W),
        .SR_W   (SR_W)
    ) u_pack (
        .ch_sel   (ch_sel),
        .buf_en   (buf_en),
        .gain_sel (gain_sel),
        .pwr_on   (pwr_on),
        .code     (code),
        .word     (load_word)
    );

    dac_tx_engine #(
        .SR_W    (SR_W),
        .FRAME_W (FRAME_W)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load_word (load_word),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .busy      (busy),
        .done      (done)
    );
endmodule

// File: rtl/dac_cmd_tx_chk.sv
module dac_cmd_tx_chk #(
    parameter int FRAME_W = 16
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic cs_n,
    input logic sclk,
    input logic mosi
);
    logic        sclk_prev;
    logic [15:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            sclk_prev <= sclk;
            if (cs_n) begin
                rise_cnt <= '0;
            end else if (sclk && !sclk_prev) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (cs_n && !sclk && !mosi && !busy && !done));

    p_cs_lead_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (!sclk && busy));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_sclk_half_r3: assert property (@(posedge clk) disable iff (rst)
        sclk |=> !sclk);

    p_frame_len_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (rise_cnt == 16'(FRAME_W)));

    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

    p_done_close_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !busy && !sclk));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !cs_n) |=> (busy || done));
endmodule

bind dac_cmd_tx dac_cmd_tx_chk #(
    .FRAME_W (dac_tx_pkg::CTRL_BITS + CODE_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .mosi  (mosi)
);

// File: tb/dac_cmd_tx_test.sv
`timescale 1ns/1ps
module dac_cmd_tx_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ch_sel = 1'b0, buf_en = 1'b0, gain_sel = 1'b0, pwr_on = 1'b0;
    logic [11:0] code = '0;
    logic        busy, done, cs_n, sclk, mosi;

    int checks = 0;
    int fails  = 0;

    logic [15:0] exp_frame = '0;

    dac_cmd_tx uut (
        .clk(clk), .rst(rst), .start(start),
        .ch_sel(ch_sel), .buf_en(buf_en), .gain_sel(gain_sel), .pwr_on(pwr_on),
        .code(code), .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Receiver model, sampled on falling system clock edges.
    logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
    logic [15:0] rx = '0;
    int          nbits = 0, cs_low_n = 0, cyc = 0, last_rise = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n && sclk && !p_sclk) begin
                if (nbits == 0)
                    chk(cs_low_n >= 1, "R2", "cs_n low cycles before first sclk rise", cs_low_n, 1);
                else
                    chk(cyc - last_rise == 2, "R3", "sclk rise spacing", cyc - last_rise, 2);
                if (!p_cs)
                    chk(mosi == p_mosi, "R5", "mosi moved at sclk rise", mosi, p_mosi);
                rx = {rx[14:0], mosi};
                nbits++;
                last_rise = cyc;
            end
            if (sclk && p_sclk)
                chk(1'b0, "R3", "sclk high for two cycles", 1, 0);
            if (cs_n && !p_cs) begin
                chk(nbits == 16, "R4", "bit count", nbits, 16);
                chk(rx == exp_frame, "R4", "received frame", rx, exp_frame);
                chk(!sclk && !p_sclk, "R6", "sclk low around cs_n rise", sclk, 0);
                chk(done == 1'b1, "R6", "done at cs_n rise", done, 1);
            end
            if (done && p_cs)
                chk(1'b0, "R6", "done without cs_n rise", 1, 0);
            if (!cs_n) cs_low_n++;
        end
        if (cs_n || rst) begin
            nbits = 0;
            cs_low_n = 0;
        end
        p_sclk = sclk;
        p_cs   = cs_n;
        p_mosi = mosi;
        cyc++;
    end

    task automatic send(input logic [3:0] ctl, input logic [11:0] cd,
                        input bit poke, input bit now);
        bit seen;
        if (!now) begin
            @(negedge clk); #2;
        end
        {ch_sel, buf_en, gain_sel, pwr_on} = ctl;
        code  = cd;
        start = 1'b1;
        exp_frame = {ctl, cd};
        @(negedge clk); #2;
        start = 1'b0;
        chk(busy && !cs_n && !sclk, "R2", "accept state busy/cs_n/sclk",
            {busy, cs_n, sclk}, 3'b100);
        if (now)
            chk(busy == 1'b1, "R9", "start in done cycle accepted", busy, 1);
        seen = 1'b0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk); #2;
            if (i == 3) begin
                // R8: scramble inputs mid-frame
                {ch_sel, buf_en, gain_sel, pwr_on} = 4'($urandom);
                code = 12'($urandom);
            end
            if (poke && i == 9) begin
                start = 1'b1;
                code  = ~cd;
            end
            if (poke && i == 10) start = 1'b0;
            if (i == 32)
                chk(busy == 1'b1, "R6", "busy during tail cycle", busy, 1);
            if (done) begin
                chk(i == 33, "R6", "done cycle index", i, 33);
                chk(busy == 1'b0, "R6", "busy low with done", busy, 0);
                seen = 1'b1;
                break;
            end
        end
        if (!seen) chk(1'b0, "R6", "done never seen", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [11:0] cds [5];
        repeat (3) @(negedge clk);
        chk({cs_n, sclk, mosi, busy, done} == 5'b10000, "R1", "reset outputs",
            {cs_n, sclk, mosi, busy, done}, 5'b10000);
        #2 rst = 1'b0;
        @(negedge clk);
        chk({cs_n, sclk, mosi, busy, done} == 5'b10000, "R1", "idle after reset",
            {cs_n, sclk, mosi, busy, done}, 5'b10000);

        // Sweep all control settings against patterned and random codes.
        for (int c = 0; c < 16; c++) begin
            cds[0] = 12'h000; cds[1] = 12'hFFF; cds[2] = 12'h555;
            cds[3] = 12'hAAA; cds[4] = 12'($urandom);
            for (int k = 0; k < 5; k++) begin
                send(4'(c), cds[k], k == 2, 1'b0);
                if (k == 2) begin
                    // R7: the mid-frame start must not spawn another frame
                    for (int w = 0; w < 5; w++) begin
                        @(negedge clk); #2;
                        chk(cs_n && !busy, "R7", "no frame after ignored start",
                            {cs_n, busy}, 2'b10);
                    end
                end
            end
        end

        // R9: back-to-back frames, start raised in the done cycle.
        send(4'hA, 12'h123, 1'b0, 1'b0);
        send(4'h5, 12'hEDC, 1'b0, 1'b1);

        // R1: reset in the middle of a frame.
        @(negedge clk); #2;
        code = 12'h3C3; {ch_sel, buf_en, gain_sel, pwr_on} = 4'hF; start = 1'b1;
        @(negedge clk); #2;
        start = 1'b0;
        repeat (8) @(negedge clk);
        #2 rst = 1'b1;
        repeat (2) @(negedge clk);
        chk({cs_n, sclk, mosi, busy, done} == 5'b10000, "R1", "mid-frame reset",
            {cs_n, sclk, mosi, busy, done}, 5'b10000);
        #2 rst = 1'b0;
        send(4'h3, 12'h9A6, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule